// File: doc/BRIEF.md
# Serial Clock Pulse Count Guard

This block sits beside the instruction decoder of a three-wire serial memory target. It counts the serial clock rising edges of a frame, from the clock edge that captured the start bit up to the moment the select line falls. When select falls it compares that count with the length the decoded instruction should have in the current organization mode. For every instruction that changes state it then issues exactly one decision strobe: commit or abort. A clock glitch adds a spurious edge and shifts the address and data by one bit. The resulting frame always has the wrong length, so the memory controller never programs a wrong word at a wrong location.

All inputs are single-cycle strobes that an upstream synchronizer has already aligned to the system clock. That synchronizer never puts a clock-rise strobe and a select-fall strobe in the same cycle. The instruction code and the organization pin are sampled in the cycle of the select-fall strobe. The decision strobe appears in the next cycle.

Top module: `clk_count_guard`

## Requirements
- R1: During reset and after it, `commit_o` and `abort_o` are low and no frame is armed.
- R2: A `start_i` strobe (which coincides with the start bit's clock rise) arms the guard with a count of 1. Each later `sclk_rise_i` strobe adds 1 until the select fall.
- R3: Write (cmd 1) and write-all (cmd 3) expect 3 + address bits + data bits. With the default widths that is 20 in byte mode (`org_i`=0: 9 address bits, 8 data bits) and 27 in word mode (`org_i`=1: 8 address bits, 16 data bits).
- R4: Erase (cmd 2), erase-all (cmd 4), write-enable (cmd 5) and write-disable (cmd 6) expect 3 + address bits. That is 12 in byte mode and 11 in word mode.
- R5: On `sel_fall_i` in an armed frame with a checked cmd, a matching count gives a one-cycle `commit_o` in the next cycle. Any other count gives a one-cycle `abort_o` instead.
- R6: Read (cmd 0) and the unused code (cmd 7) never produce either strobe, whatever the count.
- R7: A frame with one extra clock edge, or one missing edge, is aborted.
- R8: The count saturates at its all-ones value (31 by default) and does not wrap. A 52-edge byte-mode write is therefore aborted.
- R9: A select fall with no armed frame produces no strobe. A decision disarms the guard, so a second select fall gives nothing.
- R10: `commit_o` and `abort_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start bit captured (one-cycle strobe, counts as the first edge) |
| sclk_rise_i | input | 1 | Serial clock rising edge (one-cycle strobe) |
| sel_fall_i | input | 1 | Select falling edge (one-cycle strobe) |
| cmd_i | input | 3 | Decoded instruction: 0 read, 1 write, 2 erase, 3 write-all, 4 erase-all, 5 write-enable, 6 write-disable, 7 none |
| org_i | input | 1 | Organization: 0 byte, 1 word |
| commit_o | output | 1 | Frame length correct: carry out the instruction |
| abort_o | output | 1 | Frame length wrong: leave memory untouched |

## Verification
The bench builds the guard with its default widths: 9/8 address bits and 8/16 data bits, which is a 5-bit counter saturating at 31. At these widths the exact lengths 20, 27, 12 and 11 can be reached directly. A 52-edge frame is also reachable, and a wrapping counter would take that frame for a correct byte write. Random frames deviate by up to two edges from the expected length across all eight codes and both modes, so one-off and two-off glitches appear in every instruction class.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_ERASE  = 3'd2,
    CMD_WRALL  = 3'd3,
    CMD_ERALL  = 3'd4,
    CMD_WEN    = 3'd5,
    CMD_WDS    = 3'd6,
    CMD_NONE   = 3'd7
  } ccg_cmd_e;

  function automatic logic cmd_checked(input logic [2:0] c);
    return (c != CMD_READ) && (c != CMD_NONE);
  endfunction

  function automatic logic cmd_has_data(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_WRALL);
  endfunction
endpackage

// File: rtl/ccg_expect.sv
module ccg_expect #(
  parameter int ADDR_B = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_B = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [2:0]       cmd,
  input  logic             org,
  output logic [CNT_W-1:0] exp_cnt,
  output logic             checked
);
  import ccg_pkg::*;
  localparam int HDR = 3;
  localparam logic [CNT_W-1:0] SHORT_B = CNT_W'(HDR + ADDR_B);
  localparam logic [CNT_W-1:0] SHORT_W = CNT_W'(HDR + ADDR_W);
  localparam logic [CNT_W-1:0] LONG_B  = CNT_W'(HDR + ADDR_B + DATA_B);
  localparam logic [CNT_W-1:0] LONG_W  = CNT_W'(HDR + ADDR_W + DATA_W);

  always_comb begin
    checked = cmd_checked(cmd);
    if (cmd_has_data(cmd)) exp_cnt = org ? LONG_W : LONG_B;
    else                   exp_cnt = org ? SHORT_W : SHORT_B;
  end
endmodule

// File: rtl/ccg_counter.sv
module ccg_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rise,
  input  logic             fall,
  output logic             armed,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      armed <= 1'b1;
      cnt   <= CNT_W'(1);
    end else if (fall) begin
      armed <= 1'b0;
    end else if (rise && armed && cnt != SAT) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R8: saturated count stays put on further edges
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == SAT && rise && !start && !fall) |=> (cnt == SAT));
  // R2: each counted edge moves the count by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt != SAT && rise && !start && !fall) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/ccg_decide.sv
module ccg_decide #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             armed,
  input  logic             checked,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] exp_cnt,
  output logic             commit,
  output logic             abort
);
  logic judge;
  assign judge = fall && armed && checked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit <= 1'b0;
      abort  <= 1'b0;
    end else begin
      commit <= judge && (cnt == exp_cnt);
      abort  <= judge && (cnt != exp_cnt);
    end
  end

  // R10: decisions are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));
  // R5: a decision only follows a select fall
  a_r5_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> $past(fall));
  // R5: commit lasts one cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R9: unarmed select fall yields nothing
  a_r9_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !armed) |=> !(commit || abort));
endmodule

// File: rtl/clk_count_guard.sv
module clk_count_guard #(
  parameter int ADDR_B = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_B = 8,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sclk_rise_i,
  input  logic       sel_fall_i,
  input  logic [2:0] cmd_i,
  input  logic       org_i,
  output logic       commit_o,
  output logic       abort_o
);
  localparam int MAX_B = 3 + ADDR_B + DATA_B;
  localparam int MAX_W = 3 + ADDR_W + DATA_W;
  localparam int MAX_E = (MAX_B > MAX_W) ? MAX_B : MAX_W;
  localparam int CNT_W = $clog2(MAX_E + 2);

  logic             armed, checked;
  logic [CNT_W-1:0] cnt, exp_cnt;

  ccg_expect #(.ADDR_B(ADDR_B), .ADDR_W(ADDR_W), .DATA_B(DATA_B),
               .DATA_W(DATA_W), .CNT_W(CNT_W)) u_exp (
    .cmd(cmd_i), .org(org_i), .exp_cnt(exp_cnt), .checked(checked));

  ccg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start_i), .rise(sclk_rise_i),
    .fall(sel_fall_i), .armed(armed), .cnt(cnt));

  ccg_decide #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fall(sel_fall_i), .armed(armed),
    .checked(checked), .cnt(cnt), .exp_cnt(exp_cnt),
    .commit(commit_o), .abort(abort_o));

  // R6: read and unused codes never reach a decision
  a_r6_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall_i && (cmd_i == 3'd0 || cmd_i == 3'd7)) |=> !(commit_o || abort_o));
  // R9: a decision disarms the guard
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall_i && !start_i) |=> !armed);
endmodule

// File: tb/sim_clk_count_guard.sv
module sim_clk_count_guard;
  localparam int CLK_T = 10;
  localparam int SAT = 31;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, sclk_rise_i = 0, sel_fall_i = 0, org_i = 0;
  logic [2:0] cmd_i = 0;
  logic commit_o, abort_o;
  int checks = 0, errors = 0;
  bit done = 0;

  clk_count_guard u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sclk_rise_i(sclk_rise_i), .sel_fall_i(sel_fall_i), .cmd_i(cmd_i),
    .org_i(org_i), .commit_o(commit_o), .abort_o(abort_o));

  always #(CLK_T/2) clk = ~clk;

  function automatic int exp_len(input logic [2:0] c, input logic o);
    int a = o ? 8 : 9;
    int d = o ? 16 : 8;
    if (c == 3'd1 || c == 3'd3) return 3 + a + d;
    return 3 + a;
  endfunction

  function automatic bit is_checked(input logic [2:0] c);
    return c != 3'd0 && c != 3'd7;
  endfunction

  task automatic check(input string req, input logic cm, input logic ab,
                       input logic ecm, input logic eab);
    checks++;
    if (cm !== ecm || ab !== eab) begin
      errors++;
      $display("FAIL %s commit/abort actual %b%b expected %b%b", req, cm, ab, ecm, eab);
    end
  endtask

  // n edges in total; with st, the first edge carries the start strobe
  task automatic frame(input logic [2:0] c, input logic o, input int n,
                       input bit st, input string req);
    int cnt;
    bit ecm, eab;
    cmd_i = c; org_i = o;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      start_i = st && (i == 0);
      sclk_rise_i = 1;
      @(negedge clk);
      start_i = 0; sclk_rise_i = 0;
    end
    sel_fall_i = 1;
    @(negedge clk);
    sel_fall_i = 0;
    cnt = (n > SAT) ? SAT : n;
    ecm = st && n > 0 && is_checked(c) && cnt == exp_len(c, o);
    eab = st && n > 0 && is_checked(c) && cnt != exp_len(c, o);
    check(req, commit_o, abort_o, ecm, eab);
    @(negedge clk);
    check({req, " one-cycle R5"}, commit_o, abort_o, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset", commit_o, abort_o, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", commit_o, abort_o, 0, 0);

    frame(3'd1, 0, 20, 1, "R3 R2 write x8 exact");
    frame(3'd1, 1, 27, 1, "R3 write x16 exact");
    frame(3'd3, 0, 20, 1, "R3 write-all x8 exact");
    frame(3'd2, 0, 12, 1, "R4 erase x8 exact");
    frame(3'd4, 1, 11, 1, "R4 erase-all x16 exact");
    frame(3'd5, 1, 11, 1, "R4 write-enable x16 exact");
    frame(3'd6, 0, 12, 1, "R4 write-disable x8 exact");
    frame(3'd1, 0, 21, 1, "R7 write extra edge");
    frame(3'd1, 0, 19, 1, "R7 write missing edge");
    frame(3'd2, 1, 12, 1, "R7 erase extra edge");
    frame(3'd1, 0, 52, 1, "R8 saturation no wrap");
    frame(3'd1, 1, 40, 1, "R8 saturation x16");
    frame(3'd0, 0, 20, 1, "R6 read");
    frame(3'd7, 1, 11, 1, "R6 unused code");
    frame(3'd1, 0, 20, 0, "R9 no start");
    // second select fall after a decision
    sel_fall_i = 1; @(negedge clk); sel_fall_i = 0;
    check("R9 second fall", commit_o, abort_o, 0, 0);

    for (int k = 0; k < 200; k++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      logic o = 1'($urandom_range(0, 1));
      int n = exp_len(c, o) + $urandom_range(0, 4) - 2;
      if ($urandom_range(0, 1) == 0) n = exp_len(c, o);
      frame(c, o, n, 1, "R5 R10 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule